// File: doc/BRIEF.md
# Bridge Transaction Ordering Scheduler

This block sits on one direction of a transparent bus-to-bus bridge and chooses which queued transaction is offered to the target-side bus next. It keeps two queues. The first holds posted writes. The second holds delayed items: delayed read and write requests travelling this way, plus delayed completions that the opposite-direction logic hands over for return on this side. Ordering follows the producer/consumer model. A delayed item is never offered while a posted write that entered before it is still outstanding, so a read or a flag write cannot see stale data. Posted writes, however, may overtake any delayed item, which prevents deadlock.

Each delayed entry stores the number of older posted writes still queued when it was accepted. That number counts down as posted writes retire, and the entry becomes offerable at zero. When both queue heads can go, a one-bit round-robin pointer chooses between them. Once offered, an item stays on the outputs until the target side answers done or retry. A retry leaves the item at the head of its queue and passes the turn to the other queue.

Top module: `xact_order_sched`

## Requirements
- R1: Posted writes are offered and retired in exactly the order they were pushed.
- R2: A delayed item is not offered while any posted write pushed in an earlier cycle is still unretired. A posted write pushed in the same cycle as the delayed item, or later, does not block it. A posted write retiring in the cycle the delayed item is pushed does not count as ahead of it.
- R3: A posted write may be offered ahead of delayed items pushed before it.
- R4: When both queue heads are offerable and no item is held, the queue not served by the last done or retry response is offered. After reset, the posted-write queue is preferred.
- R5: On retry the offered entry stays at the head of its queue. The other queue is offered next if its head is offerable; otherwise the same entry is offered again.
- R6: An offered item, including its side, kind and payload, stays unchanged on the outputs until a done or retry response arrives.
- R7: Delayed items are offered in push order, with their 2-bit kind tag carried unchanged (0 read request, 1 write request, 2 read completion, 3 write completion). Posted writes show kind 0 and `out_is_pw` = 1.
- R8: Each queue raises its full flag at DEPTH entries. A push into a full queue is ignored and does not alter the queue contents.
- R9: After reset both queues are empty, both full flags are low and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pw_push | input | 1 | Enqueue a posted write |
| pw_data | input | DW | Posted write payload |
| pw_full | output | 1 | Posted-write queue full |
| dly_push | input | 1 | Enqueue a delayed item |
| dly_kind | input | 2 | Delayed item kind (0 rd req, 1 wr req, 2 rd cpl, 3 wr cpl) |
| dly_data | input | DW | Delayed item payload |
| dly_full | output | 1 | Delayed queue full |
| out_valid | output | 1 | An item is offered to the target side |
| out_is_pw | output | 1 | Offered item is a posted write (1) or delayed item (0) |
| out_kind | output | 2 | Kind of offered delayed item, 0 for posted writes |
| out_data | output | DW | Payload of offered item |
| tgt_done | input | 1 | Offered item completed; pops it |
| tgt_retry | input | 1 | Offered item was retried; it stays queued |

## Verification
The block has two same-cycle hazards. A posted write can retire in the same cycle that a delayed item is pushed, and a posted write and a delayed item can be pushed in the same cycle. Both cases affect the older-write count stored with the new delayed entry. The bench provokes the first by answering done on a lone posted write while pushing a delayed read. It then checks that the read is offered right after, rather than hanging. It provokes the second with a joint push followed by a retry. The retry must then hand the turn to the delayed item, which proves the new write was not counted as older.

// File: rtl/xos_pkg.sv
package xos_pkg;

   typedef enum logic [1:0] {
      DK_RD_REQ = 2'd0,
      DK_WR_REQ = 2'd1,
      DK_RD_CPL = 2'd2,
      DK_WR_CPL = 2'd3
   } dly_kind_e;

   function automatic int unsigned cnt_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   function automatic int unsigned ptr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/xos_ring.sv
module xos_ring #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW   = xos_pkg::ptr_bits(DEPTH),
   localparam int unsigned CW   = xos_pkg::cnt_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] cnt,
   output logic [DW-1:0] head
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xos_ring: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("xos_ring: DW must be at least 1");
   end

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;
   logic          push_ok, pop_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign cnt     = cnt_q;
   assign head    = mem_q[rd_q];
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + 1'b1;
      assign rd_nxt = rd_q + 1'b1;
   end else begin : g_modulo
      assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_nxt;
         if (pop_ok)  rd_q <= rd_nxt;
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_q] <= din;
   end

   // R8: a full queue that is not drained keeps its occupancy
   p_no_overflow_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop |=> cnt == $past(cnt));

   // R1: a pop advances the head by exactly one entry
   p_pop_one_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      pop && !empty && !push |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/xos_dly_queue.sv
module xos_dly_queue #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned AHW   = 3,
   localparam int unsigned AW   = xos_pkg::ptr_bits(DEPTH),
   localparam int unsigned CW   = xos_pkg::cnt_bits(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic           pop,
   input  logic [1:0]     kind_in,
   input  logic [DW-1:0]  data_in,
   input  logic [AHW-1:0] ahead_in,
   input  logic           pw_retire,
   output logic           full,
   output logic           empty,
   output logic           head_ready,
   output logic [1:0]     head_kind,
   output logic [DW-1:0]  head_data
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xos_dly_queue: DEPTH must be at least 2");
   end
   if (AHW < 1) begin : g_bad_ahw
      $error("xos_dly_queue: AHW must be at least 1");
   end

   logic [DW-1:0]  data_q  [DEPTH];
   logic [1:0]     kind_q  [DEPTH];
   logic [AHW-1:0] ahead_q [DEPTH];
   logic [AW-1:0]  wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0]  cnt_q;
   logic           push_ok, pop_ok;

   assign full       = (cnt_q == CW'(DEPTH));
   assign empty      = (cnt_q == '0);
   assign push_ok    = push && !full;
   assign pop_ok     = pop && !empty;
   assign head_kind  = kind_q[rd_q];
   assign head_data  = data_q[rd_q];
   assign head_ready = !empty && (ahead_q[rd_q] == '0);

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + 1'b1;
      assign rd_nxt = rd_q + 1'b1;
   end else begin : g_modulo
      assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_nxt;
         if (pop_ok)  rd_q <= rd_nxt;
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // Per-slot countdown of older posted writes still outstanding.
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ahead_q[s] <= '0;
         end else if (push_ok && (wr_q == AW'(s))) begin
            ahead_q[s] <= ahead_in;
         end else if (pw_retire && (ahead_q[s] != '0)) begin
            ahead_q[s] <= ahead_q[s] - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         data_q[wr_q] <= data_in;
         kind_q[wr_q] <= kind_in;
      end
   end

   // R2: a blocked head only becomes ready through a posted-write retirement
   p_ready_needs_retire_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !empty && !head_ready && !pop && !pw_retire |=> !head_ready);

   // R8: occupancy never exceeds the configured depth
   p_no_overflow_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/xos_arb.sv
module xos_arb #(
   parameter bit PW_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pw_rdy,
   input  logic dly_rdy,
   input  logic resp_done,
   input  logic resp_retry,
   output logic grant_valid,
   output logic grant_pw
);

   logic rr_pw_q;
   logic lock_q;
   logic lock_pw_q;
   logic resp;

   always_comb begin
      if (lock_q) begin
         grant_valid = 1'b1;
         grant_pw    = lock_pw_q;
      end else begin
         grant_valid = pw_rdy || dly_rdy;
         if (pw_rdy && dly_rdy) grant_pw = rr_pw_q;
         else                   grant_pw = pw_rdy;
      end
   end

   assign resp = grant_valid && (resp_done || resp_retry);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_pw_q   <= PW_FIRST;
         lock_q    <= 1'b0;
         lock_pw_q <= 1'b0;
      end else if (resp) begin
         rr_pw_q <= !grant_pw;
         lock_q  <= 1'b0;
      end else if (grant_valid) begin
         lock_q    <= 1'b1;
         lock_pw_q <= grant_pw;
      end
   end

   // R6: an unanswered offer keeps its side on the next cycle
   p_hold_offer_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && !resp_done && !resp_retry |=> grant_valid && (grant_pw == $past(grant_pw)));

   // R4 / R5: once a delayed item is answered, a waiting posted write goes next
   p_turn_to_pw_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && !grant_pw && (resp_done || resp_retry) && pw_rdy |=> grant_valid && grant_pw);

   p_resp_excl : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resp_done, resp_retry}));

endmodule

// File: rtl/xact_order_sched.sv
module xact_order_sched #(
   parameter int unsigned DW        = 8,
   parameter int unsigned PW_DEPTH  = 4,
   parameter int unsigned DLY_DEPTH = 4,
   parameter bit          PW_FIRST  = 1'b1,
   localparam int unsigned PCW      = xos_pkg::cnt_bits(PW_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pw_push,
   input  logic [DW-1:0] pw_data,
   output logic          pw_full,
   input  logic          dly_push,
   input  logic [1:0]    dly_kind,
   input  logic [DW-1:0] dly_data,
   output logic          dly_full,
   output logic          out_valid,
   output logic          out_is_pw,
   output logic [1:0]    out_kind,
   output logic [DW-1:0] out_data,
   input  logic          tgt_done,
   input  logic          tgt_retry
);

   logic           pw_empty;
   logic [PCW-1:0] pw_cnt;
   logic [DW-1:0]  pw_head;
   logic           dly_empty, dly_ready;
   logic [1:0]     dly_head_kind;
   logic [DW-1:0]  dly_head_data;
   logic           grant_valid, grant_pw;
   logic           pw_retire, dly_retire;
   logic [PCW-1:0] ahead_new;

   assign pw_retire  = grant_valid &&  grant_pw && tgt_done;
   assign dly_retire = grant_valid && !grant_pw && tgt_done;

   // Older writes for a new delayed entry: queued ones, minus one leaving now.
   assign ahead_new  = pw_cnt - PCW'(pw_retire);

   xos_ring #(.DW(DW), .DEPTH(PW_DEPTH)) u_pw_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (pw_push),
      .pop   (pw_retire),
      .din   (pw_data),
      .full  (pw_full),
      .empty (pw_empty),
      .cnt   (pw_cnt),
      .head  (pw_head)
   );

   xos_dly_queue #(.DW(DW), .DEPTH(DLY_DEPTH), .AHW(PCW)) u_dly_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (dly_push),
      .pop        (dly_retire),
      .kind_in    (dly_kind),
      .data_in    (dly_data),
      .ahead_in   (ahead_new),
      .pw_retire  (pw_retire),
      .full       (dly_full),
      .empty      (dly_empty),
      .head_ready (dly_ready),
      .head_kind  (dly_head_kind),
      .head_data  (dly_head_data)
   );

   xos_arb #(.PW_FIRST(PW_FIRST)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .pw_rdy      (!pw_empty),
      .dly_rdy     (dly_ready),
      .resp_done   (tgt_done),
      .resp_retry  (tgt_retry),
      .grant_valid (grant_valid),
      .grant_pw    (grant_pw)
   );

   assign out_valid = grant_valid;
   assign out_is_pw = grant_pw;
   assign out_kind  = grant_pw ? 2'd0 : dly_head_kind;
   assign out_data  = grant_pw ? pw_head : dly_head_data;

   // R2: a delayed item on the outputs has no older posted write outstanding
   p_dly_gate_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_is_pw |-> dly_ready);

   // R6: payload of an unanswered offer is stable
   p_stable_payload_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !tgt_done && !tgt_retry |=> $stable(out_data) && $stable(out_kind));

endmodule

// File: tb/xact_order_sched_test.sv
`timescale 1ns/1ps
module xact_order_sched_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pw_push = 1'b0, dly_push = 1'b0, tgt_done = 1'b0, tgt_retry = 1'b0;
   logic [7:0] pw_data = '0, dly_data = '0, out_data;
   logic [1:0] dly_kind = '0, out_kind;
   logic       pw_full, dly_full, out_valid, out_is_pw;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   xact_order_sched #(.DW(8), .PW_DEPTH(4), .DLY_DEPTH(4)) uut (
      .clk(clk), .rst_n(rst_n),
      .pw_push(pw_push), .pw_data(pw_data), .pw_full(pw_full),
      .dly_push(dly_push), .dly_kind(dly_kind), .dly_data(dly_data), .dly_full(dly_full),
      .out_valid(out_valid), .out_is_pw(out_is_pw), .out_kind(out_kind), .out_data(out_data),
      .tgt_done(tgt_done), .tgt_retry(tgt_retry)
   );

   task automatic cyc(input logic pp, input logic [7:0] pd, input logic dp,
                      input logic [1:0] dk, input logic [7:0] dd,
                      input logic dn, input logic rt);
      @(negedge clk);
      pw_push = pp; pw_data = pd; dly_push = dp; dly_kind = dk; dly_data = dd;
      tgt_done = dn; tgt_retry = rt;
      @(negedge clk);
      pw_push = 0; dly_push = 0; tgt_done = 0; tgt_retry = 0;
   endtask

   task automatic push_pw(input logic [7:0] d);
      cyc(1, d, 0, 2'd0, 8'h00, 0, 0);
   endtask

   task automatic push_dly(input logic [1:0] k, input logic [7:0] d);
      cyc(0, 8'h00, 1, k, d, 0, 0);
   endtask

   task automatic answer(input logic dn);
      cyc(0, 8'h00, 0, 2'd0, 8'h00, dn, !dn);
   endtask

   task automatic expect_out(input logic v, input logic ispw, input logic [1:0] k,
                             input logic [7:0] d, input string tag);
      bit bad;
      n_chk++;
      bad = (out_valid !== v);
      if (v) bad = bad || (out_is_pw !== ispw) || (out_data !== d) || (out_kind !== (ispw ? 2'd0 : k));
      if (bad) begin
         n_bad++;
         $display("FAIL %s: got v=%0b pw=%0b k=%0d d=%02h, want v=%0b pw=%0b k=%0d d=%02h",
                  tag, out_valid, out_is_pw, out_kind, out_data, v, ispw, ispw ? 2'd0 : k, d);
      end
   endtask

   task automatic expect_bit(input logic got, input logic want, input string tag);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: got %0b want %0b", tag, got, want);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got running want finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9 reset state
      expect_out(0, 0, 0, 0, "R9 idle after reset");
      expect_bit(pw_full, 0, "R9 pw_full low");
      expect_bit(dly_full, 0, "R9 dly_full low");
      rst_n = 1'b1;
      @(negedge clk);
      expect_out(0, 0, 0, 0, "R9 idle after release");

      // Lone delayed read, then writes arrive behind it
      push_dly(2'd0, 8'hA0);
      expect_out(1, 0, 2'd0, 8'hA0, "R2 no older write");
      push_pw(8'h10);
      push_pw(8'h11);
      expect_out(1, 0, 2'd0, 8'hA0, "R6 offer held");
      answer(0);
      expect_out(1, 1, 0, 8'h10, "R5 retry hands turn");
      answer(1);
      expect_out(1, 0, 2'd0, 8'hA0, "R4 alternate to delayed");
      answer(1);
      expect_out(1, 1, 0, 8'h11, "R1 second write");
      answer(1);
      expect_out(0, 0, 0, 0, "R1 drained");

      // Delayed items blocked by older writes; later write passes
      push_pw(8'h20);
      push_pw(8'h21);
      push_dly(2'd1, 8'hB0);
      push_dly(2'd2, 8'hB1);
      push_pw(8'h22);
      expect_out(1, 1, 0, 8'h20, "R2 blocked behind 20");
      answer(1);
      expect_out(1, 1, 0, 8'h21, "R2 blocked behind 21");
      answer(1);
      expect_out(1, 0, 2'd1, 8'hB0, "R4 delayed turn");
      answer(1);
      expect_out(1, 1, 0, 8'h22, "R3 write passes B1");
      answer(1);
      expect_out(1, 0, 2'd2, 8'hB1, "R7 completion kind");
      answer(1);
      expect_out(0, 0, 0, 0, "R7 drained");

      // Retry with the other queue blocked
      push_pw(8'h30);
      push_dly(2'd3, 8'hB2);
      expect_out(1, 1, 0, 8'h30, "R2 write first");
      answer(0);
      expect_out(1, 1, 0, 8'h30, "R5 re-offer same");
      answer(1);
      expect_out(1, 0, 2'd3, 8'hB2, "R7 write completion");
      answer(1);

      // Same-cycle pushes: the new write is not older
      cyc(1, 8'h40, 1, 2'd1, 8'hC0, 0, 0);
      expect_out(1, 1, 0, 8'h40, "R4 prefer write");
      answer(0);
      expect_out(1, 0, 2'd1, 8'hC0, "R2 same-cycle push not older");
      answer(1);
      expect_out(1, 1, 0, 8'h40, "R1 write after delayed");
      answer(1);

      // Retirement in the cycle of a delayed push
      push_pw(8'h50);
      cyc(0, 8'h00, 1, 2'd0, 8'hC1, 1, 0);
      expect_out(1, 0, 2'd0, 8'hC1, "R2 retire same cycle");
      answer(1);
      expect_out(0, 0, 0, 0, "R2 drained");

      // Posted queue full
      for (int i = 0; i < 5; i++) push_pw(8'h60 + 8'(i));
      expect_bit(pw_full, 1, "R8 pw_full");
      for (int i = 0; i < 4; i++) begin
         expect_out(1, 1, 0, 8'h60 + 8'(i), "R8 pw contents");
         answer(1);
      end
      expect_out(0, 0, 0, 0, "R8 fifth write dropped");
      expect_bit(pw_full, 0, "R8 pw_full cleared");

      // Delayed queue full
      for (int i = 0; i < 5; i++) push_dly(2'(i), 8'hD0 + 8'(i));
      expect_bit(dly_full, 1, "R8 dly_full");
      for (int i = 0; i < 4; i++) begin
         expect_out(1, 0, 2'(i), 8'hD0 + 8'(i), "R7 delayed order");
         answer(1);
      end
      expect_out(0, 0, 0, 0, "R8 fifth delayed dropped");

      // Sweep of older-write depth
      for (int n = 0; n < 4; n++) begin
         for (int i = 0; i < n; i++) push_pw(8'h70 + 8'(i));
         push_dly(2'd1, 8'hE0 + 8'(n));
         for (int s = 0; s <= n; s++) begin
            if (s == n) expect_out(1, 0, 2'd1, 8'hE0 + 8'(n), "R2 sweep delayed last");
            else        expect_out(1, 1, 0, 8'h70 + 8'(s), "R1 sweep write order");
            answer(1);
         end
         expect_out(0, 0, 0, 0, "R2 sweep drained");
      end

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule